// File: doc/BRIEF.md
# Priority-Level Interrupt Controller

This block decides which interrupt the processor should take next. It keeps a 5-bit current priority level, with values 0 to 31. Level 0 is ordinary code outside any handler. A set of level-sensitive hardware request lines is mapped onto levels 16 and up, and the mapping is fixed by a parameter. Software can post requests for levels 1 to 15 by writing the level number. These posted requests are held in a pending register.

Each cycle the highest pending request is compared with the current level. If its level is strictly greater, the block presents a take strobe one clock later, together with the winning level and its source. When the processor acknowledges, the current level rises to the winning level, and the previous level is pushed onto a nesting stack together with the handler's entry level. A return-from-interrupt pops that pair back. Explicit level writes may raise the level freely, but they cannot push it below the entry level of the running handler.

Top module: `ipl_arbiter`

## Requirements
- R1: After reset the current level is 0, take is low, the overflow flag is low and no software request is pending.
- R2: take rises exactly one clock after the highest pending level is strictly greater than the current level, and take_lvl then carries that level. A request at or below the current level gives no take.
- R3: Among several pending requests the highest level wins. Between hardware lines at the same level, the lowest line index wins, and take_line reports that index.
- R4: A software post sets a pending request only for levels 1 to 15. A post of level 0 or of 16 and up is ignored.
- R5: An acknowledge while take is high sets the current level to take_lvl and drops take in the next cycle. If the winner was a software request, its pending bit clears.
- R6: A return pops the saved level, so the current level returns to its value before the matching acknowledge. A return with an empty stack is ignored.
- R7: A level write of a value at or above the entry level of the running handler is applied. A write of a lower value leaves the current level equal to the entry level.
- R8: The nesting stack holds 8 entries. An acknowledge while 8 entries are held sets a sticky overflow flag, and the level is still raised.
- R9: Hardware lines are level-sensitive. A line still asserted after its handler returns is taken again.
- R10: A software request posted from a handler above its level stays pending, and it is taken only after the current level falls below it.
- R11: An acknowledge while take is low changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_req | input | HW_N | Level-sensitive hardware request lines |
| sw_post | input | 1 | Strobe to post a software request |
| sw_post_lvl | input | 5 | Level of the software request to post |
| lvl_we | input | 1 | Explicit current-level write strobe |
| lvl_wdata | input | 5 | Requested new current level |
| ack | input | 1 | Processor accepts the presented interrupt |
| rti | input | 1 | Return from interrupt |
| take | output | 1 | An interrupt is presented |
| take_lvl | output | 5 | Level of the presented interrupt |
| take_hw | output | 1 | Presented interrupt comes from a hardware line |
| take_line | output | $clog2(HW_N) | Index of the winning hardware line |
| cur_lvl | output | 5 | Current priority level |
| nest_ovf | output | 1 | Sticky nesting-stack overflow |

## Verification
The hardest state to reach is a full nesting stack, because every push needs a new request that sits strictly above the current level. The bench gets there by posting software levels 1, 2, 3 and so on in turn and acknowledging each one, which nests eight deep. A ninth acknowledge then trips the overflow, and the returns unwind the stack one entry at a time. The clamp on level writes needs a similar setup: a hardware line must first be acknowledged so that the entry level is non-zero, and the bench then writes values below, above and equal to that entry level.

// File: rtl/ipl_pkg.sv
package ipl_pkg;
  localparam int LVL_W = 5;
  typedef logic [LVL_W-1:0] lvl_t;
  // first level reserved for hardware lines; software uses 1 .. HW_FLOOR-1
  localparam lvl_t HW_FLOOR = 5'd16;
  localparam int   SW_TOP   = 15;

  typedef struct packed {
    lvl_t cur;
    lvl_t entry;
  } frame_t;
endpackage

// File: rtl/ipl_hw_pick.sv
module ipl_hw_pick
  import ipl_pkg::*;
#(
  parameter int N = 8,
  parameter int IDX_W = 3,
  parameter logic [N*LVL_W-1:0] MAP = '0
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output lvl_t             lvl,
  output logic [IDX_W-1:0] line
);
  // scan downward; ">=" lets a lower index displace an equal-level winner
  always_comb begin
    any  = 1'b0;
    lvl  = '0;
    line = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && (!any || MAP[i*LVL_W +: LVL_W] >= lvl)) begin
        any  = 1'b1;
        lvl  = MAP[i*LVL_W +: LVL_W];
        line = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/ipl_sw_pend.sv
module ipl_sw_pend
  import ipl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_we,
  input  lvl_t set_lvl,
  input  logic clr_we,
  input  lvl_t clr_lvl,
  output logic any,
  output lvl_t lvl
);
  logic [SW_TOP:1] pend_q, pend_d;
  logic            set_ok, clr_ok;

  assign set_ok = set_we && (set_lvl != '0) && (set_lvl < HW_FLOOR);
  assign clr_ok = clr_we && (clr_lvl != '0) && (clr_lvl < HW_FLOOR);

  always_comb begin
    pend_d = pend_q;
    if (clr_ok) pend_d[clr_lvl[3:0]] = 1'b0;
    if (set_ok) pend_d[set_lvl[3:0]] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else if (set_ok || clr_ok) pend_q <= pend_d;
  end

  always_comb begin
    any = 1'b0;
    lvl = '0;
    for (int i = 1; i <= SW_TOP; i++) begin
      if (pend_q[i]) begin
        any = 1'b1;
        lvl = lvl_t'(i);
      end
    end
  end
endmodule

// File: rtl/ipl_nest_stack.sv
module ipl_nest_stack
  import ipl_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   push,
  input  frame_t din,
  input  logic   pop,
  output frame_t top,
  output logic   empty,
  output logic   ovf
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  frame_t             mem [DEPTH];
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               ovf_q, ovf_d;
  logic               full, do_push, do_pop;
  logic [PTR_W-1:0]   top_idx;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !push && !empty;
  assign top_idx = PTR_W'(cnt_q - 1'b1);
  assign top     = empty ? '0 : mem[top_idx];
  assign ovf     = ovf_q;

  always_comb begin
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (do_push) cnt_d = cnt_q + 1'b1;
    else if (do_pop) cnt_d = cnt_q - 1'b1;
    if (push && full) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[PTR_W'(cnt_q)] <= din;
  end
endmodule

// File: rtl/ipl_arbiter.sv
module ipl_arbiter
  import ipl_pkg::*;
#(
  parameter int HW_N = 8,
  parameter int STACK_DEPTH = 8,
  parameter logic [HW_N*5-1:0] HW_LVL_MAP =
    {5'd16, 5'd20, 5'd20, 5'd21, 5'd22, 5'd23, 5'd24, 5'd31},
  localparam int IDX_W = (HW_N > 1) ? $clog2(HW_N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [HW_N-1:0]  hw_req,
  input  logic             sw_post,
  input  logic [4:0]       sw_post_lvl,
  input  logic             lvl_we,
  input  logic [4:0]       lvl_wdata,
  input  logic             ack,
  input  logic             rti,
  output logic             take,
  output logic [4:0]       take_lvl,
  output logic             take_hw,
  output logic [IDX_W-1:0] take_line,
  output logic [4:0]       cur_lvl,
  output logic             nest_ovf
);
  lvl_t cur_q, cur_d, entry_q, entry_d;
  logic take_q, take_d, take_hw_q, take_hw_d;
  lvl_t take_lvl_q, take_lvl_d;
  logic [IDX_W-1:0] take_line_q, take_line_d;

  logic hw_any, sw_any, ack_fire, rti_fire, wr_fire, stk_empty, cond;
  lvl_t hw_lvl, sw_lvl, best_lvl;
  logic [IDX_W-1:0] hw_line;
  frame_t stk_top, stk_din;

  ipl_hw_pick #(.N(HW_N), .IDX_W(IDX_W), .MAP(HW_LVL_MAP)) u_pick (
    .req(hw_req), .any(hw_any), .lvl(hw_lvl), .line(hw_line)
  );

  ipl_sw_pend u_sw (
    .clk(clk), .rst_n(rst_n),
    .set_we(sw_post), .set_lvl(sw_post_lvl),
    .clr_we(ack_fire && !take_hw_q), .clr_lvl(take_lvl_q),
    .any(sw_any), .lvl(sw_lvl)
  );

  assign stk_din = '{cur: cur_q, entry: entry_q};

  ipl_nest_stack #(.DEPTH(STACK_DEPTH)) u_stk (
    .clk(clk), .rst_n(rst_n),
    .push(ack_fire), .din(stk_din),
    .pop(rti_fire), .top(stk_top),
    .empty(stk_empty), .ovf(nest_ovf)
  );

  // event decode: acknowledge outranks return, return outranks write
  assign ack_fire = take_q && ack;
  assign rti_fire = rti && !ack_fire && !stk_empty;
  assign wr_fire  = lvl_we && !ack_fire && !rti;

  always_comb begin
    cur_d   = cur_q;
    entry_d = entry_q;
    if (ack_fire) begin
      cur_d   = take_lvl_q;
      entry_d = take_lvl_q;
    end else if (rti_fire) begin
      cur_d   = stk_top.cur;
      entry_d = stk_top.entry;
    end else if (wr_fire) begin
      cur_d = (lvl_wdata < entry_q) ? entry_q : lvl_wdata;
    end
  end

  // arbitration between the two sources
  always_comb begin
    take_hw_d   = hw_any && (!sw_any || hw_lvl >= sw_lvl);
    best_lvl    = take_hw_d ? hw_lvl : sw_lvl;
    take_line_d = take_hw_d ? hw_line : '0;
    take_lvl_d  = best_lvl;
    cond        = (hw_any || sw_any) && (best_lvl > cur_q);
    // a level-changing event this cycle voids the comparison just made
    take_d      = cond && !ack_fire && !rti && !lvl_we;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q   <= '0;
      entry_q <= '0;
    end else if (ack_fire || rti_fire || wr_fire) begin
      cur_q   <= cur_d;
      entry_q <= entry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      take_q      <= 1'b0;
      take_hw_q   <= 1'b0;
      take_lvl_q  <= '0;
      take_line_q <= '0;
    end else begin
      take_q      <= take_d;
      take_hw_q   <= take_hw_d;
      take_lvl_q  <= take_lvl_d;
      take_line_q <= take_line_d;
    end
  end

  assign take      = take_q;
  assign take_lvl  = take_lvl_q;
  assign take_hw   = take_hw_q;
  assign take_line = take_line_q;
  assign cur_lvl   = cur_q;
endmodule

// File: rtl/ipl_arbiter_chk.sv
module ipl_arbiter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       take,
  input logic [4:0] take_lvl,
  input logic [4:0] cur_lvl,
  input logic [4:0] entry_lvl,
  input logic       ack,
  input logic       rti,
  input logic       lvl_we,
  input logic       nest_ovf
);
  p_take_above_r2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> take_lvl > $past(cur_lvl));

  p_take_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> take_lvl != 5'd0);

  p_ack_raise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ack) |=> cur_lvl == $past(take_lvl));

  p_ack_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && ack) |=> !take);

  p_floor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cur_lvl >= entry_lvl);

  p_write_clamp_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl_we && !rti && !(take && ack)) |=> cur_lvl >= $past(entry_lvl));

  p_ovf_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    nest_ovf |=> nest_ovf);

  p_idle_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !take && !rti && !lvl_we) |=> $stable(cur_lvl));
endmodule

bind ipl_arbiter ipl_arbiter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .take(take_q), .take_lvl(take_lvl_q),
  .cur_lvl(cur_q), .entry_lvl(entry_q), .ack(ack), .rti(rti),
  .lvl_we(lvl_we), .nest_ovf(nest_ovf)
);

// File: tb/tb_ipl_arbiter.sv
module tb_ipl_arbiter;
  localparam int CLK_P = 10;
  localparam int N = 8;
  localparam int MAP [N] = '{31, 24, 23, 22, 21, 20, 20, 16};

  logic clk, rst_n;
  logic [N-1:0] hw_req;
  logic sw_post, lvl_we, ack, rti;
  logic [4:0] sw_post_lvl, lvl_wdata;
  logic take, take_hw, nest_ovf;
  logic [4:0] take_lvl, cur_lvl;
  logic [2:0] take_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  ipl_arbiter dut (
    .clk(clk), .rst_n(rst_n), .hw_req(hw_req),
    .sw_post(sw_post), .sw_post_lvl(sw_post_lvl),
    .lvl_we(lvl_we), .lvl_wdata(lvl_wdata), .ack(ack), .rti(rti),
    .take(take), .take_lvl(take_lvl), .take_hw(take_hw),
    .take_line(take_line), .cur_lvl(cur_lvl), .nest_ovf(nest_ovf)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic tick;
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr_lvl(input int v);
    lvl_we = 1'b1; lvl_wdata = 5'(v); tick; lvl_we = 1'b0;
  endtask
  task automatic do_ack;  ack = 1'b1; tick; ack = 1'b0; endtask
  task automatic do_rti;  rti = 1'b1; tick; rti = 1'b0; endtask
  task automatic post(input int v);
    sw_post = 1'b1; sw_post_lvl = 5'(v); tick; sw_post = 1'b0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hw_req = '0; sw_post = 0; sw_post_lvl = '0;
    lvl_we = 0; lvl_wdata = '0; ack = 0; rti = 0;
    repeat (3) @(posedge clk);
    #(CLK_P/4); rst_n = 1'b1;
    tick;
    // R1 reset state
    chk("R1 cur", cur_lvl, 0);
    chk("R1 take", take, 0);
    chk("R1 ovf", nest_ovf, 0);

    // R2 sweep: every current level against every hardware line
    for (int c = 0; c < 32; c++) begin
      wr_lvl(c);
      chk("R7 base write", cur_lvl, c);
      for (int i = 0; i < N; i++) begin
        hw_req = N'(1) << i; tick;
        chk("R2 take", take, (MAP[i] > c) ? 1 : 0);
        if (MAP[i] > c) begin
          chk("R2 lvl", take_lvl, MAP[i]);
          chk("R3 line", take_line, i);
        end
        hw_req = '0; tick;
      end
    end
    wr_lvl(0);

    // R3 pairs of lines
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++) begin
        hw_req = (N'(1) << i) | (N'(1) << j); tick;
        chk("R3 pair lvl", take_lvl, (MAP[j] > MAP[i]) ? MAP[j] : MAP[i]);
        chk("R3 pair line", take_line, (MAP[j] > MAP[i]) ? j : i);
      end
    hw_req = '0; tick;

    // R4 out-of-range posts ignored
    post(0); tick; chk("R4 lvl0 ignored", take, 0);
    post(16); tick; chk("R4 lvl16 ignored", take, 0);
    post(31); tick; chk("R4 lvl31 ignored", take, 0);

    // R4/R5/R6 each software level
    for (int l = 1; l < 16; l++) begin
      post(l); tick;
      chk("R4 sw take", take, 1);
      chk("R4 sw lvl", take_lvl, l);
      chk("R4 sw src", take_hw, 0);
      do_ack;
      chk("R5 cur", cur_lvl, l);
      chk("R5 drop", take, 0);
      tick;
      chk("R5 cleared", take, 0);
      do_rti;
      chk("R6 restore", cur_lvl, 0);
      tick;
      chk("R5 no retake", take, 0);
    end

    // R11 idle acknowledge
    do_ack; chk("R11 cur", cur_lvl, 0);
    // R6 return with empty stack
    wr_lvl(5); do_rti; chk("R6 empty rti", cur_lvl, 5);
    wr_lvl(0);

    // R7/R10 handler at hw level 23 posts level 4
    hw_req = N'(1) << 2; tick;
    chk("R10 hw take", take_lvl, 23);
    do_ack; chk("R5 hw cur", cur_lvl, 23);
    post(4); tick; chk("R10 held", take, 0);
    wr_lvl(10); chk("R7 clamp", cur_lvl, 23);
    wr_lvl(28); chk("R7 raise", cur_lvl, 28);
    wr_lvl(23); chk("R7 back to entry", cur_lvl, 23);
    hw_req = '0; tick; chk("R10 still held", take, 0);
    do_rti; chk("R6 hw return", cur_lvl, 0);
    tick; chk("R10 released", take, 1); chk("R10 lvl", take_lvl, 4);
    do_ack; do_rti; tick; chk("R10 done", take, 0);

    // R9 level-sensitive retake
    hw_req = N'(1); tick;
    do_ack; chk("R9 cur", cur_lvl, 31);
    tick; chk("R9 masked", take, 0);
    do_rti; tick; chk("R9 retake", take, 1); chk("R9 lvl", take_lvl, 31);
    hw_req = '0; tick; tick; chk("R9 gone", take, 0);

    // R8 nest eight deep then overflow
    for (int l = 1; l <= 9; l++) begin
      post(l); tick;
      chk("R8 nest take", take_lvl, l);
      do_ack;
      chk("R8 nest cur", cur_lvl, l);
      chk("R8 ovf", nest_ovf, (l == 9) ? 1 : 0);
    end
    for (int k = 7; k >= 0; k--) begin
      do_rti; chk("R8 unwind", cur_lvl, k);
    end
    chk("R8 sticky", nest_ovf, 1);
    do_rti; chk("R6 past bottom", cur_lvl, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule